// File: doc/BRIEF.md
# Dependent-Pair Fusing Selector

This block looks at a fixed window of decoded, RISC-style operations held in program order. It decides which producer/consumer pairs can be merged into a single fused operation. The producer is the head and the consumer is the tail. For each operation the block reports its role and the index of its partner. Each operation is described by a class code, two optional source register numbers and one optional destination register number. A translation layer uses the result to lay out fused pairs.

A `start` pulse captures the whole window. The selector then makes two passes over the window, one tail candidate per clock. The first pass offers only single-cycle ALU operations as tails. The second pass offers every operation that is still unpaired. For each tail candidate the block evaluates all earlier operations at once as possible heads and takes the nearest legal one. After the second pass `done_o` rises and the result stays stable until the next start.

Top module: `fuse_pair_selector`

## Requirements
- R1: Only an operation of class 0 (single-cycle ALU) can become a head. The other class codes are 1 multi-cycle, 2 load, 3 store and 4 branch.
- R2: The first pass visits tail candidates from index 0 upward and considers only class-0 operations as tails. Because the scan runs forward, in a chain of ALU operations the earliest legal pair is formed first.
- R3: The second pass visits every unpaired operation from index 0 upward as a tail, whatever its class. This lets a store, load, branch or multi-cycle operation become a tail.
- R4: A pair needs a valid head destination and a tail that reads that register on either of its two source ports.
- R5: Among all legal heads for one tail, the one with the highest index below the tail is chosen.
- R6: A pair is rejected if any operation strictly between head and tail writes the head's destination register.
- R7: A pair is rejected if any operation strictly between head and tail reads the head's destination register.
- R8: A pair is rejected when the valid sources of head and tail together name more than two distinct registers. Tail sources equal to the head's destination are not counted.
- R9: An operation belongs to at most one pair. role_o field i (2 bits at 2*i) is 0 unfused, 1 head or 2 tail. partner_o field i (IDX_W bits at IDX_W*i) holds the partner index, or 0 when unfused.
- R10: done_o rises exactly 2*N_OPS clock edges after the edge that accepts start. busy_o is high in between. done_o and the result hold until the next start. After reset, done_o, busy_o and all roles are 0.
- R11: For any window the reported pairing equals the two-pass rule formed by R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture the window and begin; taken when not busy |
| op_cls_i | input | N_OPS*3 | Class code per operation |
| src_a_i | input | N_OPS*REG_W | First source register per operation |
| src_a_vld_i | input | N_OPS | First source is used |
| src_b_i | input | N_OPS*REG_W | Second source register per operation |
| src_b_vld_i | input | N_OPS | Second source is used |
| dst_i | input | N_OPS*REG_W | Destination register per operation |
| dst_vld_i | input | N_OPS | Destination is written |
| busy_o | output | 1 | Passes in progress |
| done_o | output | 1 | Result valid |
| role_o | output | N_OPS*2 | Role per operation |
| partner_o | output | N_OPS*IDX_W | Partner index per operation |

## Verification
The bench uses several kinds of window, and each one isolates a single rule:
- A two-op ALU chain and a four-op ALU chain separate forward pairing from other orders.
- A load producer separates the head-class rule.
- A store and a branch consumer show second-pass tails.
- Intervening writers and readers of the head register separate the two blocking rules.
- Three-source and two-source variants of the same pair pin the source limit exactly at its boundary.
- A window where an earlier and a later producer both qualify shows the nearest-head preference.
- Random windows drawn from a small register pool produce dense, overlapping dependences, which stress the interaction of all the rules against a behavioural model.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int REG_MAX_W = 8;
  typedef logic [REG_MAX_W-1:0] reg_id_t;

  typedef enum logic [2:0] {
    CLS_ALU = 3'd0,
    CLS_MUL = 3'd1,
    CLS_LD  = 3'd2,
    CLS_ST  = 3'd3,
    CLS_BR  = 3'd4
  } op_cls_e;

  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_HEAD = 2'd1,
    ROLE_TAIL = 2'd2
  } role_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN1 = 2'd1,
    PH_SCAN2 = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  // true when an op writes or reads register r
  function automatic logic touches(input logic wv, input reg_id_t w,
                                   input logic av, input reg_id_t a,
                                   input logic bv, input reg_id_t b,
                                   input reg_id_t r);
    return (wv && (w == r)) || (av && (a == r)) || (bv && (b == r));
  endfunction

  // number of distinct registers among the valid entries
  function automatic logic [2:0] distinct_regs(input logic [3:0] v,
                                               input reg_id_t r0, input reg_id_t r1,
                                               input reg_id_t r2, input reg_id_t r3);
    reg_id_t    r [4];
    logic [2:0] n;
    logic       dup;
    r[0] = r0; r[1] = r1; r[2] = r2; r[3] = r3;
    n = 3'd0;
    for (int i = 0; i < 4; i++) begin
      dup = 1'b0;
      for (int j = 0; j < i; j++)
        if (v[j] && (r[j] == r[i])) dup = 1'b1;
      if (v[i] && !dup) n = n + 3'd1;
    end
    return n;
  endfunction
endpackage

// File: rtl/fuse_pair_check.sv
module fuse_pair_check #(
  parameter int N_OPS = 16,
  parameter int REG_W = 5,
  parameter int IDX_W = 4
) (
  input  logic [N_OPS-1:0][2:0]       cls,
  input  logic [N_OPS-1:0][REG_W-1:0] src_a,
  input  logic [N_OPS-1:0]            src_a_v,
  input  logic [N_OPS-1:0][REG_W-1:0] src_b,
  input  logic [N_OPS-1:0]            src_b_v,
  input  logic [N_OPS-1:0][REG_W-1:0] dst,
  input  logic [N_OPS-1:0]            dst_v,
  input  logic [N_OPS-1:0]            paired,
  input  logic [IDX_W-1:0]            tail,
  output logic [N_OPS-1:0]            cand
);
  import fuse_pkg::*;

  for (genvar h = 0; h < N_OPS; h++) begin : g_head
    reg_id_t    hr;
    logic       rd_a, rd_b, clash;
    logic [2:0] nsrc;

    always_comb begin
      hr   = reg_id_t'(dst[h]);
      rd_a = src_a_v[tail] && (reg_id_t'(src_a[tail]) == hr);
      rd_b = src_b_v[tail] && (reg_id_t'(src_b[tail]) == hr);
      clash = 1'b0;
      for (int k = 0; k < N_OPS; k++)
        if ((k > h) && (k < int'(tail)) &&
            touches(dst_v[k], reg_id_t'(dst[k]), src_a_v[k], reg_id_t'(src_a[k]),
                    src_b_v[k], reg_id_t'(src_b[k]), hr))
          clash = 1'b1;
      nsrc = distinct_regs({src_b_v[tail] && !rd_b, src_a_v[tail] && !rd_a,
                            src_b_v[h], src_a_v[h]},
                           reg_id_t'(src_a[h]), reg_id_t'(src_b[h]),
                           reg_id_t'(src_a[tail]), reg_id_t'(src_b[tail]));
      cand[h] = (h < int'(tail)) && !paired[h] && (cls[h] == CLS_ALU) && dst_v[h] &&
                (rd_a || rd_b) && !clash && (nsrc <= 3'd2);
    end
  end
endmodule

// File: rtl/fuse_pick.sv
module fuse_pick #(
  parameter int N_OPS = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_OPS-1:0] cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // highest set index wins: nearest earlier head
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N_OPS; i++)
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
  end
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl #(
  parameter int N_OPS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load,
  output logic             scanning,
  output logic             in_pass2,
  output logic [IDX_W-1:0] tail_idx,
  output logic             done
);
  import fuse_pkg::*;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_OPS - 1);

  phase_e phase;

  assign load     = start && ((phase == PH_IDLE) || (phase == PH_DONE));
  assign scanning = (phase == PH_SCAN1) || (phase == PH_SCAN2);
  assign in_pass2 = (phase == PH_SCAN2);
  assign done     = (phase == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      tail_idx <= '0;
    end else begin
      case (phase)
        PH_SCAN1: begin
          if (tail_idx == LAST) begin
            phase    <= PH_SCAN2;
            tail_idx <= '0;
          end else tail_idx <= tail_idx + 1'b1;
        end
        PH_SCAN2: begin
          if (tail_idx == LAST) phase <= PH_DONE;
          else tail_idx <= tail_idx + 1'b1;
        end
        default: begin
          if (load) begin
            phase    <= PH_SCAN1;
            tail_idx <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fuse_pair_selector.sv
module fuse_pair_selector #(
  parameter int N_OPS = 16,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(N_OPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [N_OPS*3-1:0]       op_cls_i,
  input  logic [N_OPS*REG_W-1:0]   src_a_i,
  input  logic [N_OPS-1:0]         src_a_vld_i,
  input  logic [N_OPS*REG_W-1:0]   src_b_i,
  input  logic [N_OPS-1:0]         src_b_vld_i,
  input  logic [N_OPS*REG_W-1:0]   dst_i,
  input  logic [N_OPS-1:0]         dst_vld_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [N_OPS*2-1:0]       role_o,
  output logic [N_OPS*IDX_W-1:0]   partner_o
);
  import fuse_pkg::*;

  logic [N_OPS-1:0][2:0]       cls_q;
  logic [N_OPS-1:0][REG_W-1:0] sa_q, sb_q, dst_q;
  logic [N_OPS-1:0]            sav_q, sbv_q, dv_q;
  logic [N_OPS-1:0][1:0]       role_q;
  logic [N_OPS-1:0][IDX_W-1:0] part_q;
  logic [N_OPS-1:0]            paired;
  logic [N_OPS-1:0]            cand_vec;

  // named internal events
  logic             load, scanning, in_pass2, done;
  logic [IDX_W-1:0] tail_idx, pick_idx;
  logic             pick_found, tail_ok, do_fuse;

  fuse_ctrl #(.N_OPS(N_OPS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .load(load), .scanning(scanning),
    .in_pass2(in_pass2), .tail_idx(tail_idx), .done(done)
  );

  fuse_pair_check #(.N_OPS(N_OPS), .REG_W(REG_W), .IDX_W(IDX_W)) u_check (
    .cls(cls_q), .src_a(sa_q), .src_a_v(sav_q), .src_b(sb_q), .src_b_v(sbv_q),
    .dst(dst_q), .dst_v(dv_q), .paired(paired), .tail(tail_idx), .cand(cand_vec)
  );

  fuse_pick #(.N_OPS(N_OPS), .IDX_W(IDX_W)) u_pick (
    .cand(cand_vec), .found(pick_found), .idx(pick_idx)
  );

  for (genvar i = 0; i < N_OPS; i++) begin : g_paired
    assign paired[i] = (role_q[i] != ROLE_NONE);
  end

  assign tail_ok = !paired[tail_idx] && (in_pass2 || (cls_q[tail_idx] == CLS_ALU));
  assign do_fuse = scanning && tail_ok && pick_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= '0; sa_q <= '0; sb_q <= '0; dst_q <= '0;
      sav_q  <= '0; sbv_q <= '0; dv_q <= '0;
      role_q <= '0; part_q <= '0;
    end else if (load) begin
      cls_q  <= op_cls_i;
      sa_q   <= src_a_i;   sav_q <= src_a_vld_i;
      sb_q   <= src_b_i;   sbv_q <= src_b_vld_i;
      dst_q  <= dst_i;     dv_q  <= dst_vld_i;
      role_q <= '0;
      part_q <= '0;
    end else if (do_fuse) begin
      role_q[pick_idx] <= ROLE_HEAD;
      part_q[pick_idx] <= tail_idx;
      role_q[tail_idx] <= ROLE_TAIL;
      part_q[tail_idx] <= pick_idx;
    end
  end

  assign busy_o    = scanning;
  assign done_o    = done;
  assign role_o    = role_q;
  assign partner_o = part_q;
endmodule

// File: rtl/fuse_pair_selector_chk.sv
module fuse_pair_selector_chk #(
  parameter int N_OPS = 16,
  parameter int IDX_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 do_fuse,
  input logic                 in_pass2,
  input logic [IDX_W-1:0]     tail_idx,
  input logic [IDX_W-1:0]     pick_idx,
  input logic [N_OPS-1:0][2:0] cls_q,
  input logic [N_OPS-1:0][1:0] role_q,
  input logic                 busy_o,
  input logic                 done_o
);
  AST_HEAD_IS_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    do_fuse |-> (cls_q[pick_idx] == 3'd0)); // R1
  AST_PASS1_ALU_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fuse && !in_pass2) |-> (cls_q[tail_idx] == 3'd0)); // R2
  AST_HEAD_BEFORE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    do_fuse |-> (pick_idx < tail_idx)); // R5
  AST_FRESH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    do_fuse |-> ((role_q[tail_idx] == 2'd0) && (role_q[pick_idx] == 2'd0))); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(role_q))); // R10
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o); // R10
endmodule

bind fuse_pair_selector fuse_pair_selector_chk #(.N_OPS(N_OPS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .do_fuse(do_fuse), .in_pass2(in_pass2),
  .tail_idx(tail_idx), .pick_idx(pick_idx), .cls_q(cls_q), .role_q(role_q),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_fuse_pair_selector.sv
module test_fuse_pair_selector;
  localparam int N  = 16;
  localparam int RW = 5;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [N*3-1:0]  op_cls_i = '0;
  logic [N*RW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [N-1:0]    src_a_vld_i = '0, src_b_vld_i = '0, dst_vld_i = '0;
  logic            busy_o, done_o;
  logic [N*2-1:0]  role_o;
  logic [N*IW-1:0] partner_o;

  fuse_pair_selector #(.N_OPS(N), .REG_W(RW)) i_fuse_pair_selector (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_cls_i(op_cls_i),
    .src_a_i(src_a_i), .src_a_vld_i(src_a_vld_i), .src_b_i(src_b_i),
    .src_b_vld_i(src_b_vld_i), .dst_i(dst_i), .dst_vld_i(dst_vld_i),
    .busy_o(busy_o), .done_o(done_o), .role_o(role_o), .partner_o(partner_o)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int w_cls[N], w_sa[N], w_sb[N], w_d[N];
  bit w_sav[N], w_sbv[N], w_dv[N];
  int e_role[N], e_part[N];

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int role_of(int i);
    return int'(role_o[i*2 +: 2]);
  endfunction
  function automatic int part_of(int i);
    return int'(partner_o[i*IW +: IW]);
  endfunction

  task automatic blank();
    for (int i = 0; i < N; i++) begin
      w_cls[i] = 4; w_sa[i] = 0; w_sb[i] = 0; w_d[i] = 0;
      w_sav[i] = 0; w_sbv[i] = 0; w_dv[i] = 0;
    end
  endtask

  // register value -1 marks an unused field
  task automatic set_op(int i, int c, int sa, int sb, int d);
    w_cls[i] = c;
    w_sav[i] = (sa >= 0); w_sa[i] = (sa >= 0) ? sa : 0;
    w_sbv[i] = (sb >= 0); w_sb[i] = (sb >= 0) ? sb : 0;
    w_dv[i]  = (d  >= 0); w_d[i]  = (d  >= 0) ? d  : 0;
  endtask

  // behavioural form of the two-pass rule
  function automatic bit legal(int h, int t, bit pd[N]);
    int r, n;
    int lst[4];
    bit ra, rb, dup;
    if (w_cls[h] != 0 || !w_dv[h] || pd[h]) return 0;
    r  = w_d[h];
    ra = w_sav[t] && w_sa[t] == r;
    rb = w_sbv[t] && w_sb[t] == r;
    if (!(ra || rb)) return 0;
    for (int k = h + 1; k < t; k++)
      if ((w_dv[k] && w_d[k] == r) || (w_sav[k] && w_sa[k] == r) || (w_sbv[k] && w_sb[k] == r))
        return 0;
    n = 0;
    if (w_sav[h]) begin lst[n] = w_sa[h]; n++; end
    if (w_sbv[h]) begin lst[n] = w_sb[h]; n++; end
    if (w_sav[t] && !ra) begin lst[n] = w_sa[t]; n++; end
    if (w_sbv[t] && !rb) begin lst[n] = w_sb[t]; n++; end
    r = 0;
    for (int i = 0; i < n; i++) begin
      dup = 0;
      for (int j = 0; j < i; j++) if (lst[j] == lst[i]) dup = 1;
      if (!dup) r++;
    end
    return r <= 2;
  endfunction

  task automatic model();
    bit pd[N];
    bit found;
    for (int i = 0; i < N; i++) begin pd[i] = 0; e_role[i] = 0; e_part[i] = 0; end
    for (int pass = 0; pass < 2; pass++)
      for (int t = 0; t < N; t++)
        if (!pd[t] && (pass == 1 || w_cls[t] == 0)) begin
          found = 0;
          for (int h = t - 1; h >= 0; h--)
            if (!found && legal(h, t, pd)) begin
              found = 1;
              pd[h] = 1; pd[t] = 1;
              e_role[h] = 1; e_part[h] = t;
              e_role[t] = 2; e_part[t] = h;
            end
        end
  endtask

  task automatic run(output int cycles);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      op_cls_i[i*3 +: 3]    = 3'(w_cls[i]);
      src_a_i[i*RW +: RW]   = RW'(w_sa[i]);
      src_b_i[i*RW +: RW]   = RW'(w_sb[i]);
      dst_i[i*RW +: RW]     = RW'(w_d[i]);
      src_a_vld_i[i] = w_sav[i];
      src_b_vld_i[i] = w_sbv[i];
      dst_vld_i[i]   = w_dv[i];
    end
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cycles = 0;
    while (!done_o && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic check_window(string req);
    model();
    for (int i = 0; i < N; i++) begin
      check(req, $sformatf("role op%0d", i), role_of(i), e_role[i]);
      check(req, $sformatf("partner op%0d", i), part_of(i), e_part[i]);
    end
  endtask

  task automatic t_reset();
    check("R10", "done after reset", int'(done_o), 0);
    check("R10", "busy after reset", int'(busy_o), 0);
    check("R10", "roles after reset", int'(role_o == '0), 1);
  endtask

  task automatic t_basic();
    int cyc;
    blank();
    set_op(0, 0, 2, -1, 1);
    set_op(1, 0, 1, -1, 3);
    @(negedge clk);
    run(cyc);
    check("R10", "cycles to done", cyc, 2 * N);
    check("R4", "op0 head", role_of(0), 1);
    check("R4", "op0 partner", part_of(0), 1);
    check("R4", "op1 tail", role_of(1), 2);
    check("R9", "op1 partner", part_of(1), 0);
    check_window("R4");
  endtask

  task automatic t_busy_window();
    // busy observed between start acceptance and done
    int seen;
    blank();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = int'(busy_o);
    check("R10", "busy after start", seen, 1);
    check("R10", "done low while busy", int'(done_o), 0);
    repeat (2 * N) @(negedge clk);
    check("R10", "done after window", int'(done_o), 1);
    check("R10", "busy cleared", int'(busy_o), 0);
  endtask

  task automatic t_load_head();
    int cyc;
    blank();
    set_op(0, 2, 5, -1, 1);
    set_op(1, 0, 1, -1, 3);
    run(cyc);
    check("R1", "load not head", role_of(0), 0);
    check("R1", "alu tail unfused", role_of(1), 0);
  endtask

  task automatic t_forward_chain();
    int cyc;
    blank();
    set_op(0, 0, 7, -1, 1);
    set_op(1, 0, 1, -1, 2);
    set_op(2, 0, 2, -1, 3);
    set_op(3, 0, 3, -1, 4);
    run(cyc);
    check("R2", "op1 tail of op0", part_of(1), 0);
    check("R2", "op1 role", role_of(1), 2);
    check("R2", "op2 head", role_of(2), 1);
    check("R2", "op3 tail of op2", part_of(3), 2);
  endtask

  task automatic t_other_tails();
    int cyc;
    blank();
    set_op(0, 0, 2, -1, 1);
    set_op(1, 3, 1, 4, -1);
    set_op(2, 0, 6, -1, 5);
    set_op(3, 4, 5, -1, -1);
    set_op(4, 0, 8, -1, 9);
    set_op(5, 2, 9, -1, 10);
    run(cyc);
    check("R3", "store tail", role_of(1), 2);
    check("R3", "store partner", part_of(1), 0);
    check("R3", "branch tail", role_of(3), 2);
    check("R3", "load tail partner", part_of(5), 4);
    check_window("R3");
  endtask

  task automatic t_nearest();
    int cyc;
    blank();
    set_op(0, 0, -1, -1, 1);
    set_op(1, 0, 3, -1, 2);
    set_op(2, 0, 1, 2, 4);
    run(cyc);
    check("R5", "nearest head chosen", part_of(2), 1);
    check("R5", "far producer unfused", role_of(0), 0);
  endtask

  task automatic t_overwrite();
    int cyc;
    blank();
    set_op(0, 0, 2, -1, 1);
    set_op(1, 2, 7, -1, 1);
    set_op(2, 0, 1, -1, 3);
    run(cyc);
    check("R6", "blocked by writer", role_of(2), 0);
    check("R6", "producer unfused", role_of(0), 0);
  endtask

  task automatic t_reader();
    int cyc;
    blank();
    set_op(0, 0, 2, -1, 1);
    set_op(1, 3, 1, -1, -1);
    set_op(2, 0, 1, -1, 3);
    run(cyc);
    check("R7", "alu tail blocked by reader", role_of(2), 0);
    check("R7", "reader paired in pass 2", part_of(1), 0);
    check("R7", "reader role", role_of(1), 2);
  endtask

  task automatic t_src_limit();
    int cyc;
    blank();
    set_op(0, 0, 2, 3, 1);
    set_op(1, 0, 1, 4, 5);
    run(cyc);
    check("R8", "three sources rejected", role_of(1), 0);
    blank();
    set_op(0, 0, 2, 3, 1);
    set_op(1, 0, 1, 2, 5);
    run(cyc);
    check("R8", "two sources accepted", role_of(1), 2);
    check("R8", "head of two-source pair", role_of(0), 1);
  endtask

  task automatic t_reuse();
    int cyc;
    blank();
    set_op(0, 0, 6, -1, 1);
    set_op(1, 0, 1, -1, 2);
    set_op(2, 0, 2, -1, 3);
    set_op(3, 3, 3, 2, -1);
    run(cyc);
    check("R9", "op1 is tail", role_of(1), 2);
    check("R9", "op2 takes no paired head", part_of(3), 2);
    check("R9", "op2 head of store", role_of(2), 1);
    check_window("R9");
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    check("R10", "done holds", int'(done_o), 1);
    check_window("R10");
  endtask

  task automatic t_random();
    int cyc, r;
    for (int n = 0; n < 200; n++) begin
      blank();
      for (int i = 0; i < N; i++) begin
        r = int'($urandom_range(0, 9));
        set_op(i, (r < 5) ? 0 : (r == 9 ? 0 : r - 4),
               ($urandom_range(0, 3) != 0) ? int'($urandom_range(0, 5)) : -1,
               ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 5)) : -1,
               ($urandom_range(0, 4) != 0) ? int'($urandom_range(0, 5)) : -1);
      end
      run(cyc);
      check("R11", "random cycles", cyc, 2 * N);
      check_window("R11");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_window();
    t_load_head();
    t_forward_chain();
    t_other_tails();
    t_nearest();
    t_overwrite();
    t_reader();
    t_src_limit();
    t_reuse();
    t_hold();
    t_random();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule